// File: doc/BRIEF.md
# Bus Address Translator

This block sits between a bus master port and a bus slave port of a classic pipelined-handshake system bus (cyc/stb/ack). It changes only the address. Every other signal passes straight through with no register on the way, in whichever direction it travels. It adds no latency, so a slave that holds ack high completes one transfer on every cycle.

The address goes through two optional stages in a fixed order. The first stage is window relocation. The incoming address is reduced modulo a power-of-two window size, and a base is then added to it. The second stage is region translation. The result of the first stage is compared against a set of source regions, each a power of two in size. On a hit, the address moves to the paired destination base and keeps its offset inside the region. An address that hits no region leaves unchanged. A parameter selects byte addressing or word addressing. In word addressing, every configured base and size is given in bytes and applied to the address divided by the bus width in bytes.

Top module: `adr_remap`

## Requirements
- R1: With window relocation enabled, the output address equals WIN_BASE plus (input address modulo 2^WIN_LOG2). With base 0x0001_0000 and window 2^28, both 0x0000_0004 and 0x1000_0004 leave as 0x0001_0004.
- R2: An address inside source region i (base SRC_BASE[i], size 2^REG_LOG2[i] bytes) leaves as DST_BASE[i] plus its offset in the region. For example, 0x0002_0008 in a 0x1000-byte region at 0x0002_0000 with destination 0x2000_0000 becomes 0x2000_0008.
- R3: When both stages are enabled, region matching is applied to the relocated address. With window base 0x1_0000 and size 0x8_0000, and a region at 0x1_0000 (size 0x1_0000) mapped to 0x1000_0000, input 0 leaves as 0x1000_0000.
- R4: An address that hits no region after relocation leaves unchanged. In the R3 configuration, input 0x2_0000 leaves as 0x3_0000. An address one byte past the end of a region is a miss.
- R5: If several source regions contain the address, the region with the lowest index decides the result.
- R6: With BYTE_ADDR=0, every base and size is divided by DW/8 (4 for a 32-bit bus). The word address output is then the byte-mode result divided by 4.
- R7: cyc, stb, we, sel, cti, bte and write data pass from master to slave unchanged. Read data, ack and err pass from slave to master unchanged, in the same cycle.
- R8: When either stage is disabled by parameter, that stage leaves the address untouched.
- R9: The translation is combinational. Back-to-back transfers with ack held high present a new translated address on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr | input | AW | Address from the master |
| m_dat_w | input | DW | Write data from the master |
| m_dat_r | output | DW | Read data to the master |
| m_sel | input | DW/8 | Byte selects from the master |
| m_cyc | input | 1 | Cycle valid from the master |
| m_stb | input | 1 | Strobe from the master |
| m_we | input | 1 | Write enable from the master |
| m_cti | input | 3 | Cycle type tag from the master |
| m_bte | input | 2 | Burst type tag from the master |
| m_ack | output | 1 | Acknowledge to the master |
| m_err | output | 1 | Error to the master |
| s_adr | output | AW | Translated address to the slave |
| s_dat_w | output | DW | Write data to the slave |
| s_dat_r | input | DW | Read data from the slave |
| s_sel | output | DW/8 | Byte selects to the slave |
| s_cyc | output | 1 | Cycle valid to the slave |
| s_stb | output | 1 | Strobe to the slave |
| s_we | output | 1 | Write enable to the slave |
| s_cti | output | 3 | Cycle type tag to the slave |
| s_bte | output | 2 | Burst type tag to the slave |
| s_ack | input | 1 | Acknowledge from the slave |
| s_err | input | 1 | Error from the slave |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between input and output. The bench therefore drives inputs on the falling clock edge and samples one nanosecond later, before the next rising edge. The back-to-back scenario changes the address on each cycle and checks every cycle, so a result that arrived one cycle late would be compared against the next expected address and fail. Four instances cover the two-stage byte-mode setup, word mode, the relocation stage alone and the region table alone.

// File: rtl/adr_remap_pkg.sv
package adr_remap_pkg;
   // all-ones in the low `bits` positions of a W-bit word
   function automatic logic [63:0] low_ones(input int bits);
      logic [63:0] m;
      m = '0;
      for (int k = 0; k < 64; k++)
         if (k < bits) m[k] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/adr_remap_origin.sv
module adr_remap_origin
   import adr_remap_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int          SHIFT    = 0,
   parameter bit          ENABLE   = 1'b1,
   parameter logic [AW-1:0] WIN_BASE = '0,
   parameter int          WIN_LOG2 = 19
) (
   input  logic [AW-1:0] a_in,
   output logic [AW-1:0] a_out
);
   localparam int              LOG_W  = WIN_LOG2 - SHIFT;
   localparam logic [AW-1:0]   BASE_W = WIN_BASE >> SHIFT;
   localparam logic [AW-1:0]   MASK_W = AW'(low_ones(LOG_W));

   generate
      if (ENABLE) begin : g_reloc
         if (LOG_W < 1 || LOG_W > AW) begin : g_bad
            $error("adr_remap_origin: window size out of range");
         end
         assign a_out = BASE_W + (a_in & MASK_W);

         always_comb begin
            // output must lie inside [base, base + window)
            AST_ORIGIN_WINDOW: assert ((a_out - BASE_W) <= MASK_W); // R1
         end
      end else begin : g_bypass
         assign a_out = a_in;
      end
   endgenerate
endmodule

// File: rtl/adr_remap_regions.sv
module adr_remap_regions
   import adr_remap_pkg::*;
#(
   parameter int                 AW        = 32,
   parameter int                 SHIFT     = 0,
   parameter bit                 ENABLE    = 1'b1,
   parameter int                 NREG      = 4,
   parameter logic [NREG*AW-1:0] SRC_BASE  = '0,
   parameter logic [NREG*AW-1:0] DST_BASE  = '0,
   parameter logic [NREG*8-1:0]  REG_LOG2  = '0
) (
   input  logic [AW-1:0] a_in,
   output logic [AW-1:0] a_out
);
   generate
      if (ENABLE) begin : g_table
         logic [NREG-1:0]         hit;
         logic [NREG-1:0]         win;
         logic [AW-1:0]           xlat [NREG];
         logic [AW-1:0]           dbase [NREG];
         logic [AW-1:0]           dmask [NREG];

         for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam int            L  = int'(REG_LOG2[i*8 +: 8]) - SHIFT;
            localparam logic [AW-1:0] M  = AW'(low_ones(L));
            localparam logic [AW-1:0] SB = SRC_BASE[i*AW +: AW] >> SHIFT;
            localparam logic [AW-1:0] DB = DST_BASE[i*AW +: AW] >> SHIFT;
            if (L < 0 || L > AW) begin : g_bad
               $error("adr_remap_regions: region size out of range");
            end
            assign hit[i]   = (((a_in ^ SB) & ~M) == '0);
            assign xlat[i]  = DB + (a_in & M);
            assign dbase[i] = DB;
            assign dmask[i] = M;
         end

         // lowest index wins
         always_comb begin
            logic seen;
            seen = 1'b0;
            win  = '0;
            for (int i = 0; i < NREG; i++) begin
               win[i] = hit[i] & ~seen;
               seen   = seen | hit[i];
            end
         end

         always_comb begin
            a_out = a_in;
            for (int i = NREG - 1; i >= 0; i--)
               if (hit[i]) a_out = xlat[i];
         end

         always_comb begin
            AST_ONE_WINNER: assert ($onehot0(win)); // R5
            AST_MISS_PASS: assert ((|hit) || (a_out == a_in)); // R4
            for (int i = 0; i < NREG; i++)
               if (win[i])
                  AST_REGION_OFFSET: assert ((a_out - dbase[i]) <= dmask[i]); // R2
         end
      end else begin : g_bypass
         assign a_out = a_in;
      end
   endgenerate
endmodule

// File: rtl/adr_remap.sv
module adr_remap #(
   parameter int                 AW        = 32,
   parameter int                 DW        = 32,
   parameter bit                 BYTE_ADDR = 1'b1,
   parameter bit                 WIN_EN    = 1'b1,
   parameter logic [AW-1:0]      WIN_BASE  = 32'h0001_0000,
   parameter int                 WIN_LOG2  = 19,
   parameter bit                 REG_EN    = 1'b1,
   parameter int                 NREG      = 4,
   parameter logic [NREG*AW-1:0] SRC_BASE  = {32'h0005_0000, 32'h0004_0000,
                                              32'h0001_0000, 32'h0001_0000},
   parameter logic [NREG*AW-1:0] DST_BASE  = {32'h3000_0000, 32'h2000_0000,
                                              32'h5000_0000, 32'h1000_0000},
   parameter logic [NREG*8-1:0]  REG_LOG2  = {8'd12, 8'd12, 8'd12, 8'd16}
) (
   input  logic [AW-1:0]   m_adr,
   input  logic [DW-1:0]   m_dat_w,
   output logic [DW-1:0]   m_dat_r,
   input  logic [DW/8-1:0] m_sel,
   input  logic            m_cyc,
   input  logic            m_stb,
   input  logic            m_we,
   input  logic [2:0]      m_cti,
   input  logic [1:0]      m_bte,
   output logic            m_ack,
   output logic            m_err,
   output logic [AW-1:0]   s_adr,
   output logic [DW-1:0]   s_dat_w,
   input  logic [DW-1:0]   s_dat_r,
   output logic [DW/8-1:0] s_sel,
   output logic            s_cyc,
   output logic            s_stb,
   output logic            s_we,
   output logic [2:0]      s_cti,
   output logic [1:0]      s_bte,
   input  logic            s_ack,
   input  logic            s_err
);
   localparam int SW    = DW / 8;
   localparam int SHIFT = BYTE_ADDR ? 0 : $clog2(SW);

   generate
      if (DW % 8 != 0 || (SW & (SW - 1)) != 0) begin : g_bad_dw
         $error("adr_remap: DW must be a power-of-two number of bytes");
      end
      if (NREG < 1) begin : g_bad_n
         $error("adr_remap: NREG must be at least 1");
      end
   endgenerate

   logic [AW-1:0] a_mid;

   adr_remap_origin #(
      .AW(AW), .SHIFT(SHIFT), .ENABLE(WIN_EN),
      .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
   ) u_origin (
      .a_in (m_adr),
      .a_out(a_mid)
   );

   adr_remap_regions #(
      .AW(AW), .SHIFT(SHIFT), .ENABLE(REG_EN), .NREG(NREG),
      .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE), .REG_LOG2(REG_LOG2)
   ) u_regions (
      .a_in (a_mid),
      .a_out(s_adr)
   );

   assign s_dat_w = m_dat_w;
   assign s_sel   = m_sel;
   assign s_cyc   = m_cyc;
   assign s_stb   = m_stb;
   assign s_we    = m_we;
   assign s_cti   = m_cti;
   assign s_bte   = m_bte;
   assign m_dat_r = s_dat_r;
   assign m_ack   = s_ack;
   assign m_err   = s_err;

   always_comb begin
      AST_STROBE_PASS: assert ((m_cyc & m_stb & m_we) == (s_cyc & s_stb & s_we)); // R7
   end
endmodule

// File: tb/sim_adr_remap.sv
module sim_adr_remap;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // shared master stimulus; word instance gets the address divided by 4
   logic [31:0] adr_b;
   logic [31:0] dat_w, dat_r;
   logic [3:0]  sel;
   logic        cyc, stb, we, ack, err;
   logic [2:0]  cti;
   logic [1:0]  bte;

   logic [31:0] o0, o1, o2, o3;
   logic [31:0] r0;
   logic [3:0]  sel0;
   logic        cyc0, stb0, we0, ack0, err0;
   logic [2:0]  cti0;
   logic [1:0]  bte0;
   logic [31:0] w0;
   logic [31:0] x1d, x2d, x3d;
   logic [3:0]  x1s, x2s, x3s;
   logic        x1c, x1t, x1w, x1a, x1e, x2c, x2t, x2w, x2a, x2e, x3c, x3t, x3w, x3a, x3e;
   logic [2:0]  x1i, x2i, x3i;
   logic [1:0]  x1b, x2b, x3b;
   logic [31:0] x1r, x2r, x3r;

   adr_remap u0 (
      .m_adr(adr_b), .m_dat_w(dat_w), .m_dat_r(r0), .m_sel(sel), .m_cyc(cyc), .m_stb(stb),
      .m_we(we), .m_cti(cti), .m_bte(bte), .m_ack(ack0), .m_err(err0),
      .s_adr(o0), .s_dat_w(w0), .s_dat_r(dat_r), .s_sel(sel0), .s_cyc(cyc0), .s_stb(stb0),
      .s_we(we0), .s_cti(cti0), .s_bte(bte0), .s_ack(ack), .s_err(err));

   adr_remap #(.BYTE_ADDR(1'b0)) u1 (
      .m_adr(adr_b >> 2), .m_dat_w(dat_w), .m_dat_r(x1r), .m_sel(sel), .m_cyc(cyc), .m_stb(stb),
      .m_we(we), .m_cti(cti), .m_bte(bte), .m_ack(x1a), .m_err(x1e),
      .s_adr(o1), .s_dat_w(x1d), .s_dat_r(dat_r), .s_sel(x1s), .s_cyc(x1c), .s_stb(x1t),
      .s_we(x1w), .s_cti(x1i), .s_bte(x1b), .s_ack(ack), .s_err(err));

   adr_remap #(.WIN_BASE(32'h0001_0000), .WIN_LOG2(28), .REG_EN(1'b0)) u2 (
      .m_adr(adr_b), .m_dat_w(dat_w), .m_dat_r(x2r), .m_sel(sel), .m_cyc(cyc), .m_stb(stb),
      .m_we(we), .m_cti(cti), .m_bte(bte), .m_ack(x2a), .m_err(x2e),
      .s_adr(o2), .s_dat_w(x2d), .s_dat_r(dat_r), .s_sel(x2s), .s_cyc(x2c), .s_stb(x2t),
      .s_we(x2w), .s_cti(x2i), .s_bte(x2b), .s_ack(ack), .s_err(err));

   adr_remap #(.WIN_EN(1'b0),
      .SRC_BASE({32'h0003_0000, 32'h0002_0000, 32'h0001_0000, 32'h0000_0000}),
      .DST_BASE({32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000}),
      .REG_LOG2({8'd12, 8'd12, 8'd12, 8'd12})) u3 (
      .m_adr(adr_b), .m_dat_w(dat_w), .m_dat_r(x3r), .m_sel(sel), .m_cyc(cyc), .m_stb(stb),
      .m_we(we), .m_cti(cti), .m_bte(bte), .m_ack(x3a), .m_err(x3e),
      .s_adr(o3), .s_dat_w(x3d), .s_dat_r(dat_r), .s_sel(x3s), .s_cyc(x3c), .s_stb(x3t),
      .s_we(x3w), .s_cti(x3i), .s_bte(x3b), .s_ack(ack), .s_err(err));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // requirement model of the default (u0) configuration, byte units
   function automatic logic [31:0] model0(input logic [31:0] a);
      logic [31:0] r;
      r = 32'h0001_0000 + (a & 32'h0007_FFFF);
      if (r[31:16] == 16'h0001)      return 32'h1000_0000 + {16'h0, r[15:0]};
      else if (r[31:12] == 20'h00040) return 32'h2000_0000 + {20'h0, r[11:0]};
      else if (r[31:12] == 20'h00050) return 32'h3000_0000 + {20'h0, r[11:0]};
      return r;
   endfunction

   task automatic put(input logic [31:0] a);
      @(negedge clk);
      adr_b = a;
      #1;
   endtask

   task automatic t_reset_idle;
      put(32'h0);
      check("R7 idle strobe", {31'h0, cyc0 | stb0}, 32'h0);
      check("R7 idle ack", {31'h0, ack0 | err0}, 32'h0);
   endtask

   task automatic t_two_stage;
      put(32'h0000_0000); check("R3 origin then region", o0, 32'h1000_0000);
      put(32'h0002_0000); check("R4 miss after origin", o0, 32'h0003_0000);
      put(32'h0008_1234); check("R1 modulo wrap", o0, 32'h1000_1234);
      put(32'h0003_0008); check("R2 region 2", o0, 32'h2000_0008);
      put(32'h0004_0FFC); check("R2 region 3 top", o0, 32'h3000_0FFC);
      put(32'h0004_1000); check("R4 one past region", o0, 32'h0005_1000);
      put(32'h0007_FFFC); check("R4 miss high", o0, 32'h0008_FFFC);
      put(32'h0000_0010); check("R5 overlap low index", o0, 32'h1000_0010);
   endtask

   task automatic t_word_mode;
      logic [31:0] v [4] = '{32'h0, 32'h0002_0000, 32'h0003_0008, 32'h0004_1000};
      foreach (v[k]) begin
         put(v[k]);
         check("R6 word address", o1, model0(v[k]) >> 2);
      end
   endtask

   task automatic t_stage_bypass;
      put(32'h0000_0004); check("R1 origin only low", o2, 32'h0001_0004);
      put(32'h1000_0004); check("R1 origin only alias", o2, 32'h0001_0004);
      check("R8 region stage off", o2, 32'h0001_0004);
      put(32'h0002_0008); check("R2 region only", o3, 32'h2000_0008);
      put(32'h0003_000C); check("R2 region only 3", o3, 32'h3000_000C);
      put(32'h0004_0000); check("R8 origin stage off miss", o3, 32'h0004_0000);
   endtask

   task automatic t_passthrough;
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; sel = 4'hA; cti = 3'd2; bte = 2'd1;
      dat_w = 32'hDEAD_BEEF; dat_r = 32'hC0FF_EE00; ack = 1; err = 1;
      #1;
      check("R7 cyc/stb/we", {29'h0, cyc0, stb0, we0}, 32'h7);
      check("R7 sel", {28'h0, sel0}, 32'hA);
      check("R7 cti/bte", {27'h0, cti0, bte0}, {27'h0, 3'd2, 2'd1});
      check("R7 write data", w0, 32'hDEAD_BEEF);
      check("R7 read data", r0, 32'hC0FF_EE00);
      check("R7 ack/err", {30'h0, ack0, err0}, 32'h3);
      @(negedge clk);
      we = 0; err = 0; sel = 4'h5; #1;
      check("R7 we low", {31'h0, we0}, 32'h0);
      check("R7 err low", {31'h0, err0}, 32'h0);
      check("R7 sel change", {28'h0, sel0}, 32'h5);
   endtask

   task automatic t_back_to_back;
      for (int k = 0; k < 16; k++) begin
         logic [31:0] a;
         a = 32'h0000_0000 + 32'(k) * 32'h0000_8004;
         put(a);
         check("R9 same-cycle address", o0, model0(a));
      end
   endtask

   initial begin
      adr_b = 0; dat_w = 0; dat_r = 0; sel = 0; cyc = 0; stb = 0; we = 0;
      cti = 0; bte = 0; ack = 0; err = 0;
      repeat (2) @(negedge clk);
      t_reset_idle();
      t_two_stage();
      t_word_mode();
      t_stage_bypass();
      t_passthrough();
      t_back_to_back();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule